// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Flush and Occupancy Controller

This block tracks which instructions occupy a six-stage in-order pipeline (fetch FI, decode DI, operand address CO, operand fetch FO, execute EI, write-back WO) and steers instruction fetch. Each cycle, the fetch side returns an instruction tag for the address on `fetch_addr`, with a flag that marks a conditional branch and that branch's target. The tag moves down one stage per cycle. The controller reports per-stage valid bits and tags, strobes completion as an instruction leaves write-back, and drives the next fetch address.

Fetch always continues sequentially past a branch, which means branches are predicted not taken. A branch is resolved only when it sits in execute. If it is taken, everything younger is discarded and the target is fetched in the very next cycle. The instruction in execute and the one in write-back still complete. An interrupt request takes the same flush-and-refetch path to its own vector. A global stall freezes the pipeline, but a flush overrides it.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: In the first cycle after a synchronous active-high reset, `stage_vld[5:1]` is all zero, `retire_vld` and `redirect_vld` are low, and `fetch_addr` equals `reset_vec`.
- R2: In a cycle with no stall and no flush, each stage's contents move one stage older at the clock edge. FI is bit 0 and carries the live `fetch_vld` and `fetch_tag`. DI is bit 1, CO bit 2, FO bit 3, EI bit 4 and WO bit 5. Stage s's tag is `stage_tag[s*TAG_W +: TAG_W]`. With back-to-back fetches, all six bits are set from the sixth cycle on.
- R3: `fetch_addr` advances by `ADDR_STEP` after each cycle with `fetch_vld` high and `stall` low. Without a flush, it holds otherwise.
- R4: An instruction fetched in cycle c with no stall or flush on its way is reported by `retire_vld` with `retire_tag` equal to its tag in cycle c+5. Nine back-to-back instructions starting in cycle 1 finish in cycle 14.
- R5: A taken branch is an EI stage that holds an instruction fetched with `fetch_is_br` high while `ex_br_taken` is high. In the next cycle, stages DI through EI are empty, `fetch_addr` equals the branch target, and `redirect_vld` is high with `redirect_addr` equal to that target.
- R6: On a flush, the instruction in EI moves to WO and completes in the next cycle. When the target is fetched right away, no completion occurs in the four cycles after that.
- R7: `irq_req` flushes the same stages and redirects to `irq_vec`. When it coincides with a taken branch, the interrupt vector wins.
- R8: With `stall` high and no flush, the stage contents and `fetch_addr` hold, the FI input is not captured, and `retire_vld` is low.
- R9: A flush acts even while `stall` is high.
- R10: `ex_br_taken` has no effect unless EI holds a valid branch. No redirect occurs and the stage contents advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | ADDR_W | Fetch address loaded by reset |
| stall | input | 1 | Freeze all stages and the fetch address |
| fetch_vld | input | 1 | An instruction is returned for `fetch_addr` this cycle |
| fetch_tag | input | TAG_W | Tag of the returned instruction |
| fetch_is_br | input | 1 | The returned instruction is a conditional branch |
| fetch_br_tgt | input | ADDR_W | Target address of that branch |
| ex_br_taken | input | 1 | The branch now in EI resolves taken |
| irq_req | input | 1 | Interrupt redirect request |
| irq_vec | input | ADDR_W | Interrupt redirect address |
| fetch_addr | output | ADDR_W | Address being fetched this cycle |
| stage_vld | output | 6 | Per-stage valid, bit 0 FI to bit 5 WO |
| stage_tag | output | 6*TAG_W | Per-stage tags, TAG_W bits per stage, FI lowest |
| retire_vld | output | 1 | The WO instruction completes this cycle |
| retire_tag | output | TAG_W | Tag of the completing instruction |
| redirect_vld | output | 1 | Fetch was redirected by the previous cycle's flush |
| redirect_addr | output | ADDR_W | Address of the last redirect |

## Verification
Two collisions carry the risk. The first is a taken branch that resolves in a cycle where `stall` is also high. The bench provokes it by raising both while the branch sits in EI, and then expects the branch to complete in the next cycle with the target on `fetch_addr`. The second is an interrupt request in the same cycle as a taken branch. There the bench expects the branch to retire and fetch to resume at the interrupt vector, not at the branch target. A scoreboard of expected completion cycles and tags catches any squashed instruction that leaks through or any survivor that goes missing.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int STAGES = 6;
  localparam int ST_FI  = 0;
  localparam int ST_DI  = 1;
  localparam int ST_CO  = 2;
  localparam int ST_FO  = 3;
  localparam int ST_EI  = 4;
  localparam int ST_WO  = 5;

  typedef enum logic [1:0] {
    REDIR_NONE   = 2'd0,
    REDIR_BRANCH = 2'd1,
    REDIR_IRQ    = 2'd2
  } redir_e;
endpackage

// File: rtl/pfc_fetch_pc.sv
module pfc_fetch_pc #(
  parameter int ADDR_W    = 16,
  parameter int ADDR_STEP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  input  logic              stall,
  input  logic              fetch_vld,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_tgt,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

  always_ff @(posedge clk) begin
    if (rst)                     pc <= reset_vec;
    else if (flush)              pc <= flush_tgt;
    else if (fetch_vld && !stall) pc <= pc + STEP;
  end
endmodule

// File: rtl/pfc_stage_regs.sv
module pfc_stage_regs #(
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 16,
  parameter int NREG   = 5,
  parameter int EI_R   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stall,
  input  logic                       flush,
  input  logic                       in_vld,
  input  logic [TAG_W-1:0]           in_tag,
  input  logic                       in_br,
  input  logic [ADDR_W-1:0]          in_tgt,
  output logic [NREG-1:0]            vld,
  output logic [NREG-1:0][TAG_W-1:0] tag,
  output logic                       ei_br,
  output logic [ADDR_W-1:0]          ei_tgt
);
  logic [EI_R:0]             br_q;
  logic [EI_R:0][ADDR_W-1:0] tgt_q;

  for (genvar r = 0; r < NREG; r++) begin : g_st
    // stages older than execute survive a flush and keep moving
    localparam bit OLD = (r > EI_R);
    logic             p_vld;
    logic [TAG_W-1:0] p_tag;
    logic             move;
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    if (r == 0) begin : g_head
      assign p_vld = in_vld;
      assign p_tag = in_tag;
    end else begin : g_body
      assign p_vld = vld[r-1];
      assign p_tag = tag[r-1];
    end

    assign move = flush ? OLD : !stall;

    always_ff @(posedge clk) begin
      if (rst)         v_q <= 1'b0;
      else if (flush)  v_q <= OLD ? p_vld : 1'b0;
      else if (!stall) v_q <= p_vld;
    end

    always_ff @(posedge clk) begin
      if (move) t_q <= p_tag;
    end

    assign vld[r] = v_q;
    assign tag[r] = t_q;

    if (r <= EI_R) begin : g_br
      logic              p_br;
      logic [ADDR_W-1:0] p_tgt;
      logic              b_q;
      logic [ADDR_W-1:0] g_q;
      if (r == 0) begin : g_bhead
        assign p_br  = in_br;
        assign p_tgt = in_tgt;
      end else begin : g_bbody
        assign p_br  = br_q[r-1];
        assign p_tgt = tgt_q[r-1];
      end
      always_ff @(posedge clk) begin
        if (move) begin
          b_q <= p_br;
          g_q <= p_tgt;
        end
      end
      assign br_q[r]  = b_q;
      assign tgt_q[r] = g_q;
    end
  end

  assign ei_br  = br_q[EI_R];
  assign ei_tgt = tgt_q[EI_R];
endmodule

// File: rtl/pfc_flush_ctl.sv
module pfc_flush_ctl
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ei_vld,
  input  logic              ei_br,
  input  logic [ADDR_W-1:0] ei_tgt,
  input  logic              br_taken,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vec,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_tgt,
  output logic              redirect_vld,
  output logic [ADDR_W-1:0] redirect_addr
);
  redir_e cause;

  always_comb begin
    cause = REDIR_NONE;
    if (irq_req)                        cause = REDIR_IRQ;
    else if (ei_vld && ei_br && br_taken) cause = REDIR_BRANCH;
  end

  assign flush     = (cause != REDIR_NONE);
  assign flush_tgt = (cause == REDIR_IRQ) ? irq_vec : ei_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld  <= 1'b0;
      redirect_addr <= '0;
    end else begin
      redirect_vld <= flush;
      if (flush) redirect_addr <= flush_tgt;
    end
  end
endmodule

// File: rtl/pipe_flush_ctrl.sv
module pipe_flush_ctrl
  import pfc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TAG_W     = 8,
  parameter int ADDR_STEP = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reset_vec,
  input  logic                    stall,
  input  logic                    fetch_vld,
  input  logic [TAG_W-1:0]        fetch_tag,
  input  logic                    fetch_is_br,
  input  logic [ADDR_W-1:0]       fetch_br_tgt,
  input  logic                    ex_br_taken,
  input  logic                    irq_req,
  input  logic [ADDR_W-1:0]       irq_vec,
  output logic [ADDR_W-1:0]       fetch_addr,
  output logic [STAGES-1:0]       stage_vld,
  output logic [STAGES*TAG_W-1:0] stage_tag,
  output logic                    retire_vld,
  output logic [TAG_W-1:0]        retire_tag,
  output logic                    redirect_vld,
  output logic [ADDR_W-1:0]       redirect_addr
);
  localparam int NREG = STAGES - 1;
  localparam int EI_R = ST_EI - 1;
  localparam int WO_R = ST_WO - 1;

  logic [NREG-1:0]            vld;
  logic [NREG-1:0][TAG_W-1:0] tag;
  logic                       ei_br;
  logic [ADDR_W-1:0]          ei_tgt;
  logic                       flush;
  logic [ADDR_W-1:0]          flush_tgt;

  pfc_flush_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .ei_vld       (vld[EI_R]),
    .ei_br        (ei_br),
    .ei_tgt       (ei_tgt),
    .br_taken     (ex_br_taken),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec),
    .flush        (flush),
    .flush_tgt    (flush_tgt),
    .redirect_vld (redirect_vld),
    .redirect_addr(redirect_addr)
  );

  pfc_stage_regs #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .NREG(NREG), .EI_R(EI_R)) u_stg (
    .clk   (clk),
    .rst   (rst),
    .stall (stall),
    .flush (flush),
    .in_vld(fetch_vld),
    .in_tag(fetch_tag),
    .in_br (fetch_is_br),
    .in_tgt(fetch_br_tgt),
    .vld   (vld),
    .tag   (tag),
    .ei_br (ei_br),
    .ei_tgt(ei_tgt)
  );

  pfc_fetch_pc #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .reset_vec(reset_vec),
    .stall    (stall),
    .fetch_vld(fetch_vld),
    .flush    (flush),
    .flush_tgt(flush_tgt),
    .pc       (fetch_addr)
  );

  // FI is the fetch cycle itself; older stages come from the registers
  assign stage_vld = {vld, fetch_vld};
  assign stage_tag[TAG_W-1:0] = fetch_tag;
  for (genvar r = 0; r < NREG; r++) begin : g_tag_out
    assign stage_tag[(r+1)*TAG_W +: TAG_W] = tag[r];
  end

  // WO leaves on every advance, and on a flush even under stall
  assign retire_vld = vld[WO_R] & (~stall | flush);
  assign retire_tag = tag[WO_R];
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    stall,
  input logic                    ex_br_taken,
  input logic                    irq_req,
  input logic [ADDR_W-1:0]       irq_vec,
  input logic [ADDR_W-1:0]       reset_vec,
  input logic                    flush,
  input logic [ADDR_W-1:0]       fetch_addr,
  input logic [STAGES-1:0]       stage_vld,
  input logic [STAGES*TAG_W-1:0] stage_tag,
  input logic                    redirect_vld,
  input logic [ADDR_W-1:0]       redirect_addr
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  AST_RESET_STATE: assert property (@(posedge clk)
    (rst_q && !rst) |-> (stage_vld[5:1] == '0 && fetch_addr == reset_vec && !redirect_vld)); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush) |=> (stage_vld[5:2] == $past(stage_vld[4:1]))); // R2

  AST_FLUSH_SQUASH: assert property (@(posedge clk) disable iff (rst)
    flush |=> (stage_vld[4:1] == '0)); // R5

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (redirect_vld && fetch_addr == redirect_addr)); // R5

  AST_EI_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (stage_vld[5] == $past(stage_vld[4]) &&
               (!stage_vld[5] || stage_tag[5*TAG_W +: TAG_W] == $past(stage_tag[4*TAG_W +: TAG_W])))); // R6

  AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> (redirect_addr == $past(irq_vec))); // R7

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(stage_vld[5:1]) && $stable(fetch_addr))); // R8

  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
    (stall && flush) |=> (redirect_vld && stage_vld[4:1] == '0)); // R9

  AST_TAKEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ex_br_taken && !stage_vld[4] && !irq_req) |=> !redirect_vld); // R10
endmodule

bind pipe_flush_ctrl pfc_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall        (stall),
  .ex_br_taken  (ex_br_taken),
  .irq_req      (irq_req),
  .irq_vec      (irq_vec),
  .reset_vec    (reset_vec),
  .flush        (flush),
  .fetch_addr   (fetch_addr),
  .stage_vld    (stage_vld),
  .stage_tag    (stage_tag),
  .redirect_vld (redirect_vld),
  .redirect_addr(redirect_addr)
);

// File: tb/tb_pipe_flush_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctrl;
  localparam int AW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] reset_vec;
  logic          stall, fetch_vld, fetch_is_br, ex_br_taken, irq_req;
  logic [TW-1:0] fetch_tag;
  logic [AW-1:0] fetch_br_tgt, irq_vec;
  logic [AW-1:0] fetch_addr;
  logic [5:0]    stage_vld;
  logic [6*TW-1:0] stage_tag;
  logic          retire_vld, redirect_vld;
  logic [TW-1:0] retire_tag;
  logic [AW-1:0] redirect_addr;

  always #4 clk = ~clk;

  pipe_flush_ctrl #(.ADDR_W(AW), .TAG_W(TW), .ADDR_STEP(1)) dut (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .stall(stall),
    .fetch_vld(fetch_vld), .fetch_tag(fetch_tag), .fetch_is_br(fetch_is_br),
    .fetch_br_tgt(fetch_br_tgt), .ex_br_taken(ex_br_taken), .irq_req(irq_req),
    .irq_vec(irq_vec), .fetch_addr(fetch_addr), .stage_vld(stage_vld),
    .stage_tag(stage_tag), .retire_vld(retire_vld), .retire_tag(retire_tag),
    .redirect_vld(redirect_vld), .redirect_addr(redirect_addr)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ret_cnt = 0;
  int redir_cnt = 0;
  int last_ret_cyc = 0;
  logic [AW-1:0] exp_pc;
  int            exp_cyc_q[$];
  logic [TW-1:0] exp_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] tag_of(input int s);
    return stage_tag[s*TW +: TW];
  endfunction

  task automatic expect_ret(input int c, input logic [TW-1:0] t);
    exp_cyc_q.push_back(c);
    exp_tag_q.push_back(t);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (redirect_vld) redir_cnt++;
      if (exp_cyc_q.size() > 0 && exp_cyc_q[0] < cyc) begin
        chk(1'b0, "R4", "missing completion", cyc, exp_cyc_q[0]);
        void'(exp_cyc_q.pop_front());
        void'(exp_tag_q.pop_front());
      end
      if (retire_vld) begin
        ret_cnt++;
        last_ret_cyc = cyc;
        if (exp_cyc_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected completion tag", int'(retire_tag), 0);
        end else begin
          chk(exp_cyc_q[0] == cyc, "R4", "completion cycle", cyc, exp_cyc_q[0]);
          chk(exp_tag_q[0] == retire_tag, "R4", "completion tag",
              int'(retire_tag), int'(exp_tag_q[0]));
          void'(exp_cyc_q.pop_front());
          void'(exp_tag_q.pop_front());
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [TW-1:0] t, input logic b,
                       input logic [AW-1:0] tg, input logic tk, input logic iq,
                       input logic st);
    chk(fetch_addr == exp_pc, "R3", "fetch_addr", int'(fetch_addr), int'(exp_pc));
    fetch_vld = v; fetch_tag = t; fetch_is_br = b; fetch_br_tgt = tg;
    ex_br_taken = tk; irq_req = iq; stall = st;
    if (v && !st) exp_pc = exp_pc + 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", "run did not finish", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0, b, d, e, s, s2, f, snap;
    rst = 1'b1; reset_vec = 16'h0100; stall = 0; fetch_vld = 0; fetch_tag = 0;
    fetch_is_br = 0; fetch_br_tgt = 0; ex_br_taken = 0; irq_req = 0; irq_vec = 0;
    exp_pc = 16'h0100;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk(stage_vld[5:1] == 5'b0, "R1", "stage_vld after reset", stage_vld, 0);
    chk(fetch_addr == 16'h0100, "R1", "fetch_addr after reset", fetch_addr, 16'h0100);
    chk(!retire_vld, "R1", "retire_vld after reset", retire_vld, 0);
    chk(!redirect_vld, "R1", "redirect_vld after reset", redirect_vld, 0);

    // R2 R4: nine back-to-back instructions, no branch
    c0 = cyc;
    for (int i = 0; i < 9; i++) begin
      if (i == 5) begin
        chk(stage_vld[5:1] == 5'b11111, "R2", "full pipeline", stage_vld, 6'h3f);
        chk(tag_of(5) == 8'd1, "R2", "WO tag", tag_of(5), 1);
        chk(tag_of(1) == 8'd5, "R2", "DI tag", tag_of(1), 5);
      end
      expect_ret(c0 + i + 5, TW'(i + 1));
      drive(1'b1, TW'(i + 1), 1'b0, '0, 1'b0, 1'b0, 1'b0);
    end
    idle(6);  // R3: address holds while fetch_vld is low
    chk(last_ret_cyc - c0 + 1 == 14, "R4", "cycles for nine", last_ret_cyc - c0 + 1, 14);

    // R5 R6: taken branch
    b = cyc;
    expect_ret(b + 5, 8'h10); drive(1, 8'h10, 0, '0, 0, 0, 0);
    expect_ret(b + 6, 8'h11); drive(1, 8'h11, 0, '0, 0, 0, 0);
    expect_ret(b + 7, 8'h12); drive(1, 8'h12, 1, 16'h0200, 0, 0, 0);
    drive(1, 8'h13, 0, '0, 0, 0, 0);
    drive(1, 8'h14, 0, '0, 0, 0, 0);
    drive(1, 8'h15, 0, '0, 0, 0, 0);
    drive(1, 8'h16, 0, '0, 1, 0, 0);
    chk(fetch_addr == 16'h0200, "R5", "fetch_addr after taken", fetch_addr, 16'h0200);
    chk(redirect_vld, "R5", "redirect_vld", redirect_vld, 1);
    chk(redirect_addr == 16'h0200, "R5", "redirect_addr", redirect_addr, 16'h0200);
    chk(stage_vld[4:1] == 4'b0, "R5", "younger stages squashed", stage_vld, 6'h20);
    chk(stage_vld[5] && tag_of(5) == 8'h12, "R6", "branch in WO", tag_of(5), 8'h12);
    exp_pc = 16'h0200;
    expect_ret(b + 12, 8'h17); drive(1, 8'h17, 0, '0, 0, 0, 0);
    snap = ret_cnt;
    idle(4);
    chk(ret_cnt == snap, "R6", "completions in penalty window", ret_cnt - snap, 0);
    idle(3);

    // R10: taken flag with no branch in EI
    snap = redir_cnt;
    e = cyc;
    expect_ret(e + 5, 8'h30); drive(1, 8'h30, 0, 16'h0777, 1, 0, 0);
    expect_ret(e + 6, 8'h31); drive(1, 8'h31, 0, 16'h0777, 1, 0, 0);
    expect_ret(e + 7, 8'h32); drive(1, 8'h32, 0, 16'h0777, 1, 0, 0);
    for (int i = 0; i < 7; i++) drive(0, '0, 0, '0, 1, 0, 0);
    chk(redir_cnt == snap, "R10", "redirects with no branch", redir_cnt - snap, 0);

    // R7: interrupt coincides with taken branch, vector wins
    d = cyc;
    irq_vec = 16'h0400;
    expect_ret(d + 5, 8'h40); drive(1, 8'h40, 1, 16'h0300, 0, 0, 0);
    drive(1, 8'h41, 0, '0, 0, 0, 0);
    drive(1, 8'h42, 0, '0, 0, 0, 0);
    drive(1, 8'h43, 0, '0, 0, 0, 0);
    drive(1, 8'h44, 0, '0, 1, 1, 0);
    chk(fetch_addr == 16'h0400, "R7", "fetch_addr priority", fetch_addr, 16'h0400);
    chk(redirect_addr == 16'h0400, "R7", "redirect_addr priority", redirect_addr, 16'h0400);
    exp_pc = 16'h0400;
    idle(6);

    // R7: interrupt alone squashes young instructions
    irq_vec = 16'h0480;
    drive(1, 8'h50, 0, '0, 0, 0, 0);
    drive(1, 8'h51, 0, '0, 0, 0, 0);
    drive(1, 8'h52, 0, '0, 0, 1, 0);
    chk(fetch_addr == 16'h0480, "R7", "fetch_addr irq", fetch_addr, 16'h0480);
    chk(redirect_vld && stage_vld[4:1] == 4'b0, "R7", "irq flush", stage_vld, 0);
    exp_pc = 16'h0480;
    idle(7);

    // R8: stall freezes contents and suppresses completion
    s = cyc;
    expect_ret(s + 8, 8'h60); drive(1, 8'h60, 0, '0, 0, 0, 0);
    expect_ret(s + 9, 8'h61); drive(1, 8'h61, 0, '0, 0, 0, 0);
    drive(1, 8'h99, 0, '0, 0, 0, 1);
    drive(1, 8'h99, 0, '0, 0, 0, 1);
    chk(stage_vld[5:1] == 5'b00011 && tag_of(2) == 8'h60, "R8", "frozen CO", tag_of(2), 8'h60);
    drive(1, 8'h99, 0, '0, 0, 0, 1);
    idle(8);
    s2 = cyc;
    expect_ret(s2 + 6, 8'h62); drive(1, 8'h62, 0, '0, 0, 0, 0);
    idle(4);
    drive(0, '0, 0, '0, 0, 0, 1);
    idle(3);

    // R9: flush while stalled
    f = cyc;
    expect_ret(f + 5, 8'h70); drive(1, 8'h70, 1, 16'h0500, 0, 0, 0);
    idle(3);
    drive(0, '0, 0, '0, 1, 0, 1);
    chk(fetch_addr == 16'h0500, "R9", "fetch_addr under stall", fetch_addr, 16'h0500);
    chk(redirect_vld, "R9", "redirect under stall", redirect_vld, 1);
    chk(stage_vld[5] && tag_of(5) == 8'h70, "R9", "branch moved to WO", tag_of(5), 8'h70);
    exp_pc = 16'h0500;
    idle(6);

    chk(exp_cyc_q.size() == 0, "R4", "outstanding completions", exp_cyc_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule